// File: doc/BRIEF.md
# Load Value Forwarding Queue

Two redundant copies of a program run side by side. Only the copy that runs ahead (the leading side) is allowed to read memory. Each load it performs is written into this queue as an address and value pair. The copy that runs behind (the trailing side) never touches memory for its loads. Instead it presents its own load address to the queue, and the queue checks that address against the oldest stored entry. When the two agree, the stored value is returned one cycle later and the entry is retired. When they differ, a fault is raised, no data is returned and the entry stays at the head, so recovery can start from a known point.

Entries leave the queue strictly in the order they arrived, which is the commit order of the leading side. The leading side is held off while every slot is in use, and a trailing request is held off while the queue is empty. A synchronous flush discards every stored entry when recovery begins.

Top module: `load_fwd_queue`

## Requirements
- R1: After reset the queue is empty: `lead_ready` is 1, `trail_ready` is 0, and both `resp_valid` and `fault` are 0.
- R2: Trailing requests receive values in the same order in which the leading side wrote them.
- R3: A trailing request that is accepted (`trail_valid` and `trail_ready` both high) and whose address equals the head address gives `resp_valid`=1 in the next cycle, with `resp_data` holding the head value, and removes that entry.
- R4: An accepted request whose address differs from the head address gives `fault`=1 and `resp_valid`=0 in the next cycle. The head entry is kept, so a later request with the right address still receives that entry's value.
- R5: While the queue is empty, `trail_ready` is 0. A request made then produces neither `resp_valid` nor `fault` in the next cycle.
- R6: Once DEPTH entries are stored, `lead_ready` is 0, and a write offered in that state is dropped.
- R7: A write and a matching trailing request in the same cycle are both carried out. The order of later entries is kept.
- R8: `flush` high at a clock edge empties the queue, and a write or request offered in that same cycle is ignored. After that edge, `trail_ready` is 0 and `lead_ready` is 1.
- R9: `resp_valid` and `fault` are never high in the same cycle, and each is high only in the cycle after an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous discard of all entries |
| lead_valid | input | 1 | Leading side offers a load pair |
| lead_ready | output | 1 | A free slot exists |
| lead_addr | input | ADDR_W | Address of the leading load |
| lead_data | input | DATA_W | Value read by the leading load |
| trail_valid | input | 1 | Trailing side requests its load value |
| trail_ready | output | 1 | Head entry available for checking |
| trail_addr | input | ADDR_W | Address computed by the trailing load |
| resp_valid | output | 1 | Value returned for the previous matching request |
| resp_data | output | DATA_W | Returned load value |
| fault | output | 1 | Previous request's address did not match the head |

## Verification
The assertions assume that the inputs are driven to known values whenever reset is released. They also assume that `flush` is only ever a synchronous pulse. The properties that use `$past` compare across a single edge, so they never look back into the reset period. The bench changes inputs only on falling edges and raises one handshake per operation. It overlaps a write with a request only in the R7 and R8 cases, where the expected outcome of the overlap is worked out in advance from a small occupancy model kept in the bench.

// File: rtl/lfq_pkg.sv
package lfq_pkg;

  typedef enum logic [1:0] {
    CHK_IDLE = 2'd0,
    CHK_HIT  = 2'd1,
    CHK_MISS = 2'd2
  } lfq_chk_e;

  // circular index advance for a ring of `depth` slots
  function automatic int unsigned lfq_wrap_inc(input int unsigned idx, input int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // occupancy after one cycle of optional insert and optional remove
  function automatic int unsigned lfq_occ_next(input int unsigned occ, input logic ins, input logic rem);
    return occ + {31'd0, ins} - {31'd0, rem};
  endfunction

endpackage

// File: rtl/lfq_store.sv
module lfq_store
  import lfq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [IDX_W-1:0]  head_idx,
  output logic [CNT_W-1:0]  occupancy,
  output logic              full,
  output logic              empty
);

  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [IDX_W-1:0]  wr_ptr;
  logic [IDX_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= IDX_W'(lfq_wrap_inc(32'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= IDX_W'(lfq_wrap_inc(32'(rd_ptr), DEPTH));
      count <= CNT_W'(lfq_occ_next(32'(count), wr_en, rd_en));
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      slot_addr[wr_ptr] <= wr_addr;
      slot_data[wr_ptr] <= wr_data;
    end
  end

  assign head_addr = slot_addr[rd_ptr];
  assign head_data = slot_data[rd_ptr];
  assign head_idx  = rd_ptr;
  assign occupancy = count;
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);

  // R6: occupancy never exceeds the slot count
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R6: the write strobe arriving from the control logic never hits a full ring
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);

  // R5: no removal is requested from an empty ring
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);

  // R8: a flush leaves nothing stored
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

endmodule

// File: rtl/lfq_check.sv
module lfq_check
  import lfq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic              head_present,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  output logic              pop,
  output lfq_chk_e          outcome,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              fault
);

  logic accept;
  logic same_addr;

  assign accept    = req_valid && head_present && !flush;
  assign same_addr = (req_addr == head_addr);

  always_comb begin
    outcome = CHK_IDLE;
    if (accept) outcome = same_addr ? CHK_HIT : CHK_MISS;
  end

  assign pop = (outcome == CHK_HIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      fault      <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= (outcome == CHK_HIT);
      fault      <= (outcome == CHK_MISS);
      if (outcome == CHK_HIT) resp_data <= head_data;
    end
  end

  // R3: a hit returns the head value one cycle later
  assert_hit_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == CHK_HIT) |=> (resp_valid && resp_data == $past(head_data)));

  // R4: a miss raises the fault and withholds data
  assert_miss_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (outcome == CHK_MISS) |=> (fault && !resp_valid));

  // R9: the two response flags are exclusive
  assert_resp_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && fault));

  // R9: a flag only follows a request
  assert_resp_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_valid && !fault));

endmodule

// File: rtl/load_fwd_queue.sv
module load_fwd_queue
  import lfq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lead_valid,
  output logic              lead_ready,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic [DATA_W-1:0] lead_data,
  input  logic              trail_valid,
  output logic              trail_ready,
  input  logic [ADDR_W-1:0] trail_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              fault
);

  logic              q_full;
  logic              q_empty;
  logic              push_evt;
  logic              pop_evt;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic [IDX_W-1:0]  head_idx;
  logic [CNT_W-1:0]  occupancy;
  lfq_chk_e          chk_outcome;

  assign lead_ready  = !q_full;
  assign trail_ready = !q_empty;
  assign push_evt    = lead_valid && !q_full && !flush;

  lfq_store #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (push_evt),
    .wr_addr  (lead_addr),
    .wr_data  (lead_data),
    .rd_en    (pop_evt),
    .head_addr(head_addr),
    .head_data(head_data),
    .head_idx (head_idx),
    .occupancy(occupancy),
    .full     (q_full),
    .empty    (q_empty)
  );

  lfq_check #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .req_valid   (trail_valid),
    .head_present(!q_empty),
    .req_addr    (trail_addr),
    .head_addr   (head_addr),
    .head_data   (head_data),
    .pop         (pop_evt),
    .outcome     (chk_outcome),
    .resp_valid  (resp_valid),
    .resp_data   (resp_data),
    .fault       (fault)
  );

  // R4: a miss keeps the head in place
  assert_miss_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_outcome == CHK_MISS) |=> $stable(head_idx));

  // R5: a request while empty produces no response
  assert_empty_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_valid && !trail_ready) |=> (!resp_valid && !fault));

  // R7: a write and a hit in the same cycle leave the occupancy unchanged
  assert_overlap_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && chk_outcome == CHK_HIT) |=> $stable(occupancy));

endmodule

// File: tb/load_fwd_queue_test.sv
`timescale 1ns/1ps
module load_fwd_queue_test;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          lead_valid = 1'b0;
  logic          lead_ready;
  logic [AW-1:0] lead_addr = '0;
  logic [DW-1:0] lead_data = '0;
  logic          trail_valid = 1'b0;
  logic          trail_ready;
  logic [AW-1:0] trail_addr = '0;
  logic          resp_valid;
  logic [DW-1:0] resp_data;
  logic          fault;

  int compared = 0;
  int mismatched = 0;
  int model_cnt = 0;
  int push_idx = 0;
  int pop_idx = 0;
  bit done = 0;

  always #2 clk = ~clk;

  load_fwd_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lead_valid(lead_valid), .lead_ready(lead_ready),
    .lead_addr(lead_addr), .lead_data(lead_data),
    .trail_valid(trail_valid), .trail_ready(trail_ready),
    .trail_addr(trail_addr),
    .resp_valid(resp_valid), .resp_data(resp_data), .fault(fault)
  );

  function automatic logic [AW-1:0] seq_addr(input int i);
    return AW'(i * 37 + 11);
  endfunction

  function automatic logic [DW-1:0] seq_data(input int i);
    return DW'(i * 613 + 16'h1234);
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_one();
    @(negedge clk);
    check_eq("R6 lead_ready", 32'(lead_ready), 32'(model_cnt < DP));
    lead_valid = 1'b1;
    lead_addr  = seq_addr(push_idx);
    lead_data  = seq_data(push_idx);
    @(negedge clk);
    lead_valid = 1'b0;
    if (model_cnt < DP) begin
      model_cnt++;
      push_idx++;
    end
  endtask

  task automatic pop_one(input bit corrupt);
    @(negedge clk);
    check_eq("R5 trail_ready", 32'(trail_ready), 32'(model_cnt > 0));
    trail_valid = 1'b1;
    trail_addr  = seq_addr(pop_idx) ^ (corrupt ? AW'(8'h5A) : AW'(0));
    @(negedge clk);
    trail_valid = 1'b0;
    check_eq("R9 exclusive", 32'(resp_valid && fault), 32'd0);
    if (model_cnt == 0) begin
      check_eq("R5 no resp", 32'(resp_valid), 32'd0);
      check_eq("R5 no fault", 32'(fault), 32'd0);
    end else if (corrupt) begin
      check_eq("R4 fault", 32'(fault), 32'd1);
      check_eq("R4 no data", 32'(resp_valid), 32'd0);
    end else begin
      check_eq("R3 resp_valid", 32'(resp_valid), 32'd1);
      check_eq("R2 order data", 32'(resp_data), 32'(seq_data(pop_idx)));
      pop_idx++;
      model_cnt--;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 lead_ready", 32'(lead_ready), 32'd1);
    check_eq("R1 trail_ready", 32'(trail_ready), 32'd0);
    check_eq("R1 resp_valid", 32'(resp_valid), 32'd0);
    check_eq("R1 fault", 32'(fault), 32'd0);

    // R5 request on empty queue
    pop_one(1'b0);

    // R6 fill beyond capacity, then drain in order (R2)
    for (int i = 0; i < DP + 1; i++) push_one();
    check_eq("R6 full ready", 32'(lead_ready), 32'd0);
    for (int i = 0; i < DP; i++) pop_one(1'b0);
    check_eq("R6 dropped write", 32'(trail_ready), 32'd0);

    // R4 mismatch keeps head
    push_one(); push_one();
    pop_one(1'b1);
    pop_one(1'b1);
    pop_one(1'b0);
    pop_one(1'b0);

    // R7 overlapping write and matching request
    push_one();
    @(negedge clk);
    lead_valid  = 1'b1;
    lead_addr   = seq_addr(push_idx);
    lead_data   = seq_data(push_idx);
    trail_valid = 1'b1;
    trail_addr  = seq_addr(pop_idx);
    @(negedge clk);
    lead_valid  = 1'b0;
    trail_valid = 1'b0;
    check_eq("R7 resp_valid", 32'(resp_valid), 32'd1);
    check_eq("R7 resp_data", 32'(resp_data), 32'(seq_data(pop_idx)));
    pop_idx++;
    push_idx++;
    check_eq("R7 one left", 32'(trail_ready), 32'd1);
    pop_one(1'b0);
    check_eq("R7 drained", 32'(trail_ready), 32'd0);

    // R8 flush with a simultaneous write and request
    push_one(); push_one(); push_one();
    @(negedge clk);
    flush       = 1'b1;
    lead_valid  = 1'b1;
    lead_addr   = seq_addr(push_idx);
    lead_data   = seq_data(push_idx);
    trail_valid = 1'b1;
    trail_addr  = seq_addr(pop_idx);
    @(negedge clk);
    flush       = 1'b0;
    lead_valid  = 1'b0;
    trail_valid = 1'b0;
    check_eq("R8 trail_ready", 32'(trail_ready), 32'd0);
    check_eq("R8 lead_ready", 32'(lead_ready), 32'd1);
    check_eq("R8 no resp", 32'(resp_valid), 32'd0);
    model_cnt = 0;
    pop_idx   = push_idx;

    // sweep every fill level with one mismatch at each position
    for (int k = 1; k <= DP; k++) begin
      for (int j = 0; j < k; j++) begin
        for (int p = 0; p < k; p++) push_one();
        for (int p = 0; p < k; p++) begin
          if (p == j) pop_one(1'b1);
          pop_one(1'b0);
        end
        check_eq("R2 sweep empty", 32'(trail_ready), 32'd0);
      end
    end

    finish_run();
  end

endmodule